// File: doc/BRIEF.md
# Clock Divider Power-Down Sequencer

This block owns the run/stop state of a small audio clock-divider tree. There are two chains of two stages each. On the playback side a first-stage divider feeds a second-stage divider. The record side has the same shape. Software raises start and stop requests for each divider. The block grants a stop only when the tree's ordering rules allow it. A stop that cannot be granted yet is held, and the divider keeps running until the stop becomes safe. A fifth divider produces the serial bit clock and has no ordering constraints.

The channels' own shut-down sequences are not part of this block. Each channel reports two power-status flags. A divider that feeds a channel keeps running until both of that channel's flags read powered down. A second stage always stops before its first stage. Two routing options add cross-channel constraints. The first routes the record clock from the playback first stage. The second feeds the record oversampling divider from the playback modulator clock. All outputs are clock-enable signals on the single master clock. The block drives no gated clocks.

Top module: `clkdiv_pwr_seq`

## Requirements
- R1: After reset all five divider enables, every pending bit, the pending summary and the bit-clock pulse are 0.
- R2: A start request for a divider sets its enable at the next clock edge and clears its pending stop bit. If a start and a stop for the same divider arrive in the same cycle, the start wins.
- R3: Neither playback divider (index 0 first stage, index 1 second stage) is stopped unless the playback flags read 2'b11 (both powered down). One flag alone is not enough.
- R4: In each chain the first stage (index 0 playback, index 2 record) stops only in a cycle after its second stage (index 1 or 3) is already off. When stops for both stages are requested together, the second stage goes off one cycle before the first.
- R5: Neither record divider (index 2 or 3) is stopped unless the record flags read 2'b11.
- R6: While the record clock is sourced from the playback first stage, index 0 also waits for record flags 2'b11 and for index 2 to be off.
- R7: While the record oversampling divider is fed from the playback modulator clock and the record frame clock is needed, index 1 also waits for record flags 2'b11. When the frame clock is not needed, this extra condition does not apply.
- R8: A blocked stop is latched into its pending bit, and the pending summary is high while any bit is set. The stop executes at the first clock edge where its conditions hold. A stop for a divider that is already off is ignored.
- R9: A modulator-run output is high exactly when both stages of its chain are enabled.
- R10: With index 4 enabled and bit-clock drive mode on, the bit-clock pulse occurs once every N cycles. N is the 7-bit ratio field, and the code 0 means 128. With drive mode off, no pulse occurs.
- R11: A stop for the bit-clock divider (index 4) takes effect at the next edge with no conditions.
- R12: A start request that arrives while a stop is pending cancels that stop, and the divider stays on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_req | input | 5 | Per-divider start request (bit = divider index) |
| stop_req | input | 5 | Per-divider stop request |
| play_pd | input | 2 | Playback channel power-down flags, 1 = down |
| rec_pd | input | 2 | Record channel power-down flags, 1 = down |
| rec_from_play | input | 1 | Record clock sourced from playback first stage |
| osr_from_playmod | input | 1 | Record oversampling divider fed by playback modulator clock |
| rec_fs_needed | input | 1 | Record frame clock required |
| bclk_drive | input | 1 | Bit-clock output drive mode |
| bclk_ratio | input | 7 | Bit-clock divide ratio, 0 means 128 |
| div_en | output | 5 | Divider enables |
| pend_mask | output | 5 | Pending stop per divider |
| pending | output | 1 | Any stop pending |
| play_mod_run | output | 1 | Playback modulator clock running |
| rec_mod_run | output | 1 | Record modulator clock running |
| bclk_ce | output | 1 | Bit-clock clock-enable pulse |

## Verification
The table raises stop requests against each combination of flags and routing options. It tries one flag versus both flags, which shows whether the check needs both flags or either one. It stops the two stages of a chain together, which exposes the one-cycle ordering gap. It turns each routing option on and off, which shows whether the cross-channel holds are applied only when their routing is selected. Directed tests cover a start and a stop in the same cycle, and bit-clock ratios of 1, 4 and code 0. Counting pulses in fixed windows at these ratios tells a correct period apart from an off-by-one period and from a wrong decoding of the 128 case.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  localparam int NDIV     = 5;
  localparam int D_PLAY1  = 0;
  localparam int D_PLAY2  = 1;
  localparam int D_REC1   = 2;
  localparam int D_REC2   = 3;
  localparam int D_BCLK   = 4;

  function automatic logic both_down(input logic [1:0] flags);
    return flags == 2'b11;
  endfunction
endpackage

// File: rtl/clkdiv_rules.sv
module clkdiv_rules
  import clkdiv_pkg::*;
(
  input  logic [NDIV-1:0] en_q,
  input  logic [1:0]      play_pd,
  input  logic [1:0]      rec_pd,
  input  logic            rec_from_play,
  input  logic            osr_from_playmod,
  input  logic            rec_fs_needed,
  output logic [NDIV-1:0] stop_ok
);
  logic play_down, rec_down, osr_hold;

  always_comb begin
    play_down = both_down(play_pd);
    rec_down  = both_down(rec_pd);
    osr_hold  = osr_from_playmod && rec_fs_needed && !rec_down;
    stop_ok[D_PLAY2] = play_down && !osr_hold;
    stop_ok[D_PLAY1] = play_down && !en_q[D_PLAY2] &&
                       (!rec_from_play || (rec_down && !en_q[D_REC1]));
    stop_ok[D_REC2]  = rec_down;
    stop_ok[D_REC1]  = rec_down && !en_q[D_REC2];
    stop_ok[D_BCLK]  = 1'b1;
  end
endmodule

// File: rtl/clkdiv_en_ctrl.sv
module clkdiv_en_ctrl
  import clkdiv_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NDIV-1:0] start_req,
  input  logic [NDIV-1:0] stop_req,
  input  logic [NDIV-1:0] stop_ok,
  output logic [NDIV-1:0] en_q,
  output logic [NDIV-1:0] pend_q,
  output logic [NDIV-1:0] grant
);
  logic [NDIV-1:0] want_stop;

  always_comb begin
    want_stop = (pend_q | (stop_req & en_q)) & ~start_req;
    grant     = want_stop & stop_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      pend_q <= '0;
    end else begin
      en_q   <= (en_q & ~grant) | start_req;
      pend_q <= want_stop & ~grant;
    end
  end
endmodule

// File: rtl/clkdiv_bclk_gen.sv
module clkdiv_bclk_gen #(
  parameter int RW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [RW-1:0] ratio_code,
  output logic          ce
);
  localparam int CW = RW + 1;

  function automatic logic [CW-1:0] decode_ratio(input logic [RW-1:0] code);
    if (code == '0) return CW'(1) << RW;
    return CW'(code);
  endfunction

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] last;

  always_comb begin
    last = decode_ratio(ratio_code) - CW'(1);
    ce   = run && (cnt_q >= last);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (!run)     cnt_q <= '0;
    else if (ce)       cnt_q <= '0;
    else               cnt_q <= cnt_q + CW'(1);
  end
endmodule

// File: rtl/clkdiv_pwr_seq.sv
module clkdiv_pwr_seq
  import clkdiv_pkg::*;
#(
  parameter int RW = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NDIV-1:0] start_req,
  input  logic [NDIV-1:0] stop_req,
  input  logic [1:0]      play_pd,
  input  logic [1:0]      rec_pd,
  input  logic            rec_from_play,
  input  logic            osr_from_playmod,
  input  logic            rec_fs_needed,
  input  logic            bclk_drive,
  input  logic [RW-1:0]   bclk_ratio,
  output logic [NDIV-1:0] div_en,
  output logic [NDIV-1:0] pend_mask,
  output logic            pending,
  output logic            play_mod_run,
  output logic            rec_mod_run,
  output logic            bclk_ce
);
  logic [NDIV-1:0] stop_ok;
  logic [NDIV-1:0] grant;
  logic            bclk_run;

  clkdiv_rules u_rules (
    .en_q(div_en), .play_pd(play_pd), .rec_pd(rec_pd),
    .rec_from_play(rec_from_play), .osr_from_playmod(osr_from_playmod),
    .rec_fs_needed(rec_fs_needed), .stop_ok(stop_ok)
  );

  clkdiv_en_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .stop_req(stop_req),
    .stop_ok(stop_ok), .en_q(div_en), .pend_q(pend_mask), .grant(grant)
  );

  assign bclk_run = div_en[D_BCLK] && bclk_drive;

  clkdiv_bclk_gen #(.RW(RW)) u_bclk (
    .clk(clk), .rst_n(rst_n), .run(bclk_run), .ratio_code(bclk_ratio),
    .ce(bclk_ce)
  );

  assign pending      = |pend_mask;
  assign play_mod_run = div_en[D_PLAY1] && div_en[D_PLAY2];
  assign rec_mod_run  = div_en[D_REC1] && div_en[D_REC2];
endmodule

// File: rtl/clkdiv_pwr_seq_chk.sv
module clkdiv_pwr_seq_chk
  import clkdiv_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic [NDIV-1:0] start_req,
  input logic [1:0]      play_pd,
  input logic [1:0]      rec_pd,
  input logic            rec_from_play,
  input logic            osr_from_playmod,
  input logic            rec_fs_needed,
  input logic            bclk_drive,
  input logic [NDIV-1:0] div_en,
  input logic [NDIV-1:0] pend_mask,
  input logic [NDIV-1:0] grant,
  input logic            bclk_ce
);
  p_play2_flags_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(div_en[D_PLAY2]) |-> $past(play_pd) == 2'b11);
  p_play1_flags_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(div_en[D_PLAY1]) |-> $past(play_pd) == 2'b11);
  p_rec_flags_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(div_en[D_REC1]) || $fell(div_en[D_REC2])) |-> $past(rec_pd) == 2'b11);
  p_play_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(div_en[D_PLAY1]) |-> !$past(div_en[D_PLAY2]));
  p_rec_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(div_en[D_REC1]) |-> !$past(div_en[D_REC2]));
  p_src_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(div_en[D_PLAY1]) && $past(rec_from_play)) |->
      ($past(rec_pd) == 2'b11 && !$past(div_en[D_REC1])));
  p_osr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(div_en[D_PLAY2]) && $past(osr_from_playmod) && $past(rec_fs_needed))
      |-> $past(rec_pd) == 2'b11);
  p_start_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|start_req) |=> (((div_en & $past(start_req)) == $past(start_req)) &&
                      ((pend_mask & $past(start_req)) == '0)));
  p_pend_live_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_mask & ~div_en) == '0);
  p_grant_stops_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|grant) |=> ((div_en & $past(grant)) == '0));
  p_bclk_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bclk_ce |-> (div_en[D_BCLK] && bclk_drive));
endmodule

bind clkdiv_pwr_seq clkdiv_pwr_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start_req(start_req), .play_pd(play_pd),
  .rec_pd(rec_pd), .rec_from_play(rec_from_play),
  .osr_from_playmod(osr_from_playmod), .rec_fs_needed(rec_fs_needed),
  .bclk_drive(bclk_drive), .div_en(div_en), .pend_mask(pend_mask),
  .grant(grant), .bclk_ce(bclk_ce)
);

// File: tb/tb_clkdiv_pwr_seq.sv
`timescale 1ns/1ps
module tb_clkdiv_pwr_seq;
  logic       clk = 0;
  logic       rst_n = 0;
  logic [4:0] start_req = '0, stop_req = '0;
  logic [1:0] play_pd = '0, rec_pd = '0;
  logic       rec_from_play = 0, osr_from_playmod = 0, rec_fs_needed = 0;
  logic       bclk_drive = 0;
  logic [6:0] bclk_ratio = 7'd4;
  logic [4:0] div_en, pend_mask;
  logic       pending, play_mod_run, rec_mod_run, bclk_ce;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  clkdiv_pwr_seq dut (.*);

  // {start, stop, play_pd, rec_pd, {rec_from_play, osr, fs}, exp_en, exp_pend}
  localparam int NV = 22;
  localparam logic [26:0] VEC [NV] = '{
    {5'b11111, 5'b00000, 2'b00, 2'b00, 3'b000, 5'b11111, 5'b00000}, // R2
    {5'b00000, 5'b00010, 2'b00, 2'b00, 3'b000, 5'b11111, 5'b00010}, // R3 blocked
    {5'b00000, 5'b00000, 2'b01, 2'b00, 3'b000, 5'b11111, 5'b00010}, // R3 one flag
    {5'b00000, 5'b00000, 2'b11, 2'b00, 3'b000, 5'b11101, 5'b00000}, // R8 executes
    {5'b00000, 5'b00001, 2'b11, 2'b00, 3'b000, 5'b11100, 5'b00000}, // R4
    {5'b00011, 5'b00000, 2'b00, 2'b00, 3'b000, 5'b11111, 5'b00000},
    {5'b00000, 5'b01000, 2'b00, 2'b10, 3'b000, 5'b11111, 5'b01000}, // R5
    {5'b01000, 5'b00000, 2'b00, 2'b10, 3'b000, 5'b11111, 5'b00000}, // R12
    {5'b00000, 5'b01100, 2'b00, 2'b11, 3'b000, 5'b10111, 5'b00100}, // R4 rec
    {5'b00000, 5'b00000, 2'b00, 2'b11, 3'b000, 5'b10011, 5'b00000}, // R4 rec
    {5'b01100, 5'b00000, 2'b00, 2'b00, 3'b000, 5'b11111, 5'b00000},
    {5'b00000, 5'b00011, 2'b11, 2'b00, 3'b100, 5'b11101, 5'b00001}, // R6
    {5'b00000, 5'b00000, 2'b11, 2'b11, 3'b100, 5'b11101, 5'b00001}, // R6 rec1 on
    {5'b00000, 5'b01100, 2'b11, 2'b11, 3'b100, 5'b10101, 5'b00101},
    {5'b00000, 5'b00000, 2'b11, 2'b11, 3'b100, 5'b10001, 5'b00001},
    {5'b00000, 5'b00000, 2'b11, 2'b11, 3'b100, 5'b10000, 5'b00000}, // R6
    {5'b01111, 5'b00000, 2'b00, 2'b00, 3'b000, 5'b11111, 5'b00000},
    {5'b00000, 5'b00010, 2'b11, 2'b00, 3'b011, 5'b11111, 5'b00010}, // R7
    {5'b00000, 5'b00000, 2'b11, 2'b00, 3'b010, 5'b11101, 5'b00000}, // R7 fs off
    {5'b00010, 5'b00000, 2'b00, 2'b00, 3'b011, 5'b11111, 5'b00000},
    {5'b00000, 5'b00010, 2'b11, 2'b11, 3'b011, 5'b11101, 5'b00000}, // R7
    {5'b00000, 5'b10010, 2'b11, 2'b11, 3'b000, 5'b01101, 5'b00000}  // R11, R8
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cycle();
    @(posedge clk);
    @(negedge clk);
    start_req = '0;
    stop_req  = '0;
  endtask

  task automatic count_pulses(input int cycles, output int pulses);
    pulses = 0;
    for (int k = 0; k < cycles; k++) begin
      if (bclk_ce) pulses++;
      @(negedge clk);
    end
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int p;
    logic [4:0] e_en;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(div_en == 0 && pend_mask == 0 && !pending && !bclk_ce, "R1", div_en, 0);
    rst_n = 1;
    @(negedge clk);
    check(div_en == 0 && !pending, "R1 after release", div_en, 0);

    for (int i = 0; i < NV; i++) begin
      start_req        = VEC[i][26:22];
      stop_req         = VEC[i][21:17];
      play_pd          = VEC[i][16:15];
      rec_pd           = VEC[i][14:13];
      rec_from_play    = VEC[i][12];
      osr_from_playmod = VEC[i][11];
      rec_fs_needed    = VEC[i][10];
      e_en             = VEC[i][9:5];
      cycle();
      check(div_en == e_en, $sformatf("R2-table en vec%0d", i), div_en, e_en);
      check(pend_mask == VEC[i][4:0] && pending == (|VEC[i][4:0]),
            $sformatf("R8 pending vec%0d", i), pend_mask, VEC[i][4:0]);
      check(play_mod_run == (e_en[0] & e_en[1]) && rec_mod_run == (e_en[2] & e_en[3]),
            "R9 mod run", {play_mod_run, rec_mod_run}, {e_en[0] & e_en[1], e_en[2] & e_en[3]});
    end

    // R2: start and stop together, start wins (divider 4 is off; turn on then race)
    rec_from_play = 0; osr_from_playmod = 0; rec_fs_needed = 0;
    start_req = 5'b10000; cycle();
    start_req = 5'b10000; stop_req = 5'b10000; cycle();
    check(div_en[4] && !pend_mask[4], "R2 start beats stop", div_en, 5'b11101);

    // R10: drive off, no pulses
    bclk_drive = 0;
    count_pulses(20, p);
    check(p == 0, "R10 drive off", p, 0);
    // R10: ratio 4
    start_req = 5'b00000; stop_req = 5'b10000; cycle();
    bclk_ratio = 7'd4; bclk_drive = 1;
    start_req = 5'b10000; cycle();
    count_pulses(40, p);
    check(p == 10, "R10 ratio 4", p, 10);
    // R10: ratio 1
    stop_req = 5'b10000; cycle();
    check(!div_en[4] && !bclk_ce, "R11 bclk stop", div_en[4], 0);
    bclk_ratio = 7'd1;
    start_req = 5'b10000; cycle();
    count_pulses(10, p);
    check(p == 10, "R10 ratio 1", p, 10);
    // R10: code 0 = 128
    stop_req = 5'b10000; cycle();
    bclk_ratio = 7'd0;
    start_req = 5'b10000; cycle();
    count_pulses(256, p);
    check(p == 2, "R10 ratio code 0", p, 2);
    count_pulses(127, p);
    check(p == 0, "R10 ratio code 0 gap", p, 0);
    count_pulses(1, p);
    check(p == 1, "R10 ratio code 0 edge", p, 1);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule